// File: doc/BRIEF.md
# Symbol Timing Error Detector

This block measures symbol timing error for a pair of baseband rails (in-phase and quadrature) that are sampled twice per symbol. The sample stream alternates between a sample taken half way through a symbol and a sample taken at the symbol boundary. Each boundary sample is reduced to a hard decision by its sign. When the decision on a rail differs from that rail's previous boundary decision, the sample taken between the two boundaries measures how far the sampling instant is from the zero crossing. That sample, signed by the direction of the change, is the rail's timing error. A rail whose decision did not change contributes nothing.

The error can come from the in-phase rail alone or from the sum of both rails, as set by a mode input. One result strobe is produced per symbol, one clock after the boundary sample. A freeze input suppresses the result update for a symbol loop filter further downstream. The decision history keeps tracking the input while frozen.

Top module: `symbol_ted`

## Requirements
- R1: While reset is asserted, and after it is released until the first result, `err` is 0 and `err_vld` is 0.
- R2: The hard decision of a boundary sample is 1 when the sample is zero or positive (sign bit 0) and 0 when it is negative (sign bit 1).
- R3: When a rail's decision goes from 0 to 1, the rail's contribution is plus the most recent mid sample of that rail.
- R4: When a rail's decision goes from 1 to 0, the rail's contribution is minus the most recent mid sample of that rail, computed one bit wider so that negating the most negative sample does not overflow.
- R5: When a rail's decision is equal to its previous decision, the rail contributes zero.
- R6: With `double_rail` = 0, `err` equals the in-phase contribution and quadrature samples have no effect on `err`.
- R7: With `double_rail` = 1, `err` is the sum of both contributions in SMP_W+2 bits, so that two contributions of +2^(SMP_W-1) give +2^SMP_W without wrapping.
- R8: A boundary sample (`smp_vld`=1, `smp_is_end`=1) that updates the result makes `err_vld` high for exactly the next cycle, with the new `err` valid in that same cycle.
- R9: The first boundary sample after reset produces no strobe, because no earlier decision exists.
- R10: While `freeze` is 1 at a boundary sample, `err_vld` stays 0 and `err` keeps its value. The decision is still updated, so the next boundary sample is compared with the decision made during freeze.
- R11: A mid sample (`smp_vld`=1, `smp_is_end`=0) produces no strobe and overwrites the stored mid sample of each rail. Only the latest one before a boundary sample is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | A sample pair is present this cycle |
| smp_is_end | input | 1 | 1: boundary sample, 0: mid sample |
| smp_i | input | SMP_W | In-phase sample, two's complement |
| smp_q | input | SMP_W | Quadrature sample, two's complement |
| double_rail | input | 1 | 0: in-phase only, 1: both rails summed |
| freeze | input | 1 | Hold the result update |
| err | output | SMP_W+2 | Timing error, two's complement |
| err_vld | output | 1 | One-cycle strobe marking a new `err` |

## Verification
The hardest case to reach is the one where decision history and result update come apart. A boundary sample arrives under freeze and carries a real transition. The symbol after it has to be scored against that frozen-time decision and not against the older one. The stimulus sets this up on purpose: a rising in-phase decision, then a frozen falling one, then an unfrozen rising one whose expected error is non-zero only when the frozen decision was recorded. The table also drives both rails to the most negative mid sample with falling decisions, which exercises the widening of the sum. The first symbol after a second, mid-run reset is driven to confirm that the stored decision counts as missing.

// File: rtl/ted_pkg.sv
package ted_pkg;

  typedef enum logic [1:0] {
    TR_NONE = 2'd0,
    TR_UP   = 2'd1,
    TR_DOWN = 2'd2
  } trans_e;

endpackage

// File: rtl/ted_rst_sync.sv
module ted_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) pipe_q <= '0;
    else           pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = pipe_q[STAGES-1];

endmodule

// File: rtl/ted_rail.sv
module ted_rail
  import ted_pkg::*;
#(
  parameter int SMP_W = 10,
  localparam int CW = SMP_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic                    smp_is_end,
  input  logic signed [SMP_W-1:0] smp,
  output logic signed [CW-1:0]    contrib
);

  logic                    dec_q, dec_d;
  logic signed [SMP_W-1:0] mid_q, mid_d;
  logic                    new_dec;
  logic signed [CW-1:0]    mid_ext;
  trans_e                  tr;

  always_comb begin
    new_dec = ~smp[SMP_W-1];
    mid_ext = {mid_q[SMP_W-1], mid_q};
    if (new_dec == dec_q) tr = TR_NONE;
    else if (new_dec)     tr = TR_UP;
    else                  tr = TR_DOWN;
    case (tr)
      TR_UP:   contrib = mid_ext;
      TR_DOWN: contrib = -mid_ext;
      default: contrib = '0;
    endcase
  end

  always_comb begin
    dec_d = dec_q;
    mid_d = mid_q;
    if (smp_vld && smp_is_end)  dec_d = new_dec;
    if (smp_vld && !smp_is_end) mid_d = smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q <= 1'b0;
      mid_q <= '0;
    end else begin
      dec_q <= dec_d;
      mid_q <= mid_d;
    end
  end

  // R11
  mid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_vld && !smp_is_end) |=> $stable(mid_q));

  // R2
  dec_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && smp_is_end) |=> (dec_q == !$past(smp[SMP_W-1])));

endmodule

// File: rtl/ted_combine.sv
module ted_combine #(
  parameter int SMP_W = 10,
  localparam int CW = SMP_W + 1,
  localparam int EW = SMP_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 end_stb,
  input  logic                 freeze,
  input  logic                 double_rail,
  input  logic signed [CW-1:0] contrib_i,
  input  logic signed [CW-1:0] contrib_q,
  output logic signed [EW-1:0] err,
  output logic                 err_vld
);

  logic                 primed_q, primed_d;
  logic signed [EW-1:0] err_q, err_d;
  logic                 vld_q, vld_d;
  logic signed [EW-1:0] ext_i, ext_q, sum;
  logic                 upd;

  always_comb begin
    ext_i = {contrib_i[CW-1], contrib_i};
    ext_q = double_rail ? {contrib_q[CW-1], contrib_q} : '0;
    sum   = ext_i + ext_q;
    upd   = end_stb && primed_q && !freeze;
    primed_d = primed_q | end_stb;
    err_d    = upd ? sum : err_q;
    vld_d    = upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      err_q    <= '0;
      vld_q    <= 1'b0;
    end else begin
      primed_q <= primed_d;
      err_q    <= err_d;
      vld_q    <= vld_d;
    end
  end

  assign err     = err_q;
  assign err_vld = vld_q;

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!end_stb || freeze) |=> $stable(err));

  // R8
  vld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |-> $past(end_stb && !freeze));

endmodule

// File: rtl/symbol_ted.sv
module symbol_ted
  import ted_pkg::*;
#(
  parameter int SMP_W = 10,
  localparam int CW = SMP_W + 1,
  localparam int EW = SMP_W + 2,
  localparam int NRAIL = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic                    smp_is_end,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic signed [SMP_W-1:0] smp_q,
  input  logic                    double_rail,
  input  logic                    freeze,
  output logic signed [EW-1:0]    err,
  output logic                    err_vld
);

  logic                    rst_n_s;
  logic signed [SMP_W-1:0] rail_smp [NRAIL];
  logic signed [CW-1:0]    rail_con [NRAIL];

  assign rail_smp[0] = smp_i;
  assign rail_smp[1] = smp_q;

  ted_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  for (genvar r = 0; r < NRAIL; r++) begin : g_rail
    ted_rail #(.SMP_W(SMP_W)) u_rail (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .smp_vld    (smp_vld),
      .smp_is_end (smp_is_end),
      .smp        (rail_smp[r]),
      .contrib    (rail_con[r])
    );
  end

  ted_combine #(.SMP_W(SMP_W)) u_comb (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .end_stb     (smp_vld && smp_is_end),
    .freeze      (freeze),
    .double_rail (double_rail),
    .contrib_i   (rail_con[0]),
    .contrib_q   (rail_con[1]),
    .err         (err),
    .err_vld     (err_vld)
  );

endmodule

// File: tb/symbol_ted_test.sv
module symbol_ted_test;

  localparam int CLK_PERIOD = 10;
  localparam int SMP_W = 10;
  localparam int EW = SMP_W + 2;
  localparam int NV = 10;

  // per symbol: mid I, mid Q, end I, end Q, double rail, expected err
  localparam int MI [NV] = '{ 100, -40,  200, -512, 511, -512, 60,  33,  25, 511};
  localparam int MQ [NV] = '{  50,  30, -300, -512,  77, -512, -90, 44, -70, 511};
  localparam int EI [NV] = '{  -3,   0,    9,   -1,   4,   -2,  3,   1,  -5,   7};
  localparam int EQ [NV] = '{   7,  -1,   -9,    5,   8,   -2,  3,  -1,   5,   7};
  localparam int DB [NV] = '{   1,   1,    1,    1,   1,    1,  0,   0,   1,   1};
  localparam int EX [NV] = '{-100, -70,    0,    0, 511, 1024, 60,   0, -95, 511};
  localparam string RQ [NV] = '{"R4", "R3", "R5", "R4", "R3", "R7", "R6", "R6", "R7", "R5"};

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    smp_vld;
  logic                    smp_is_end;
  logic signed [SMP_W-1:0] smp_i;
  logic signed [SMP_W-1:0] smp_q;
  logic                    double_rail;
  logic                    freeze;
  logic signed [EW-1:0]    err;
  logic                    err_vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  symbol_ted #(.SMP_W(SMP_W)) uut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_is_end(smp_is_end),
    .smp_i(smp_i), .smp_q(smp_q), .double_rail(double_rail), .freeze(freeze),
    .err(err), .err_vld(err_vld)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drives one sample at a falling edge; outputs are read at the next falling edge
  task automatic drive(input bit is_end, input int i, input int q);
    smp_vld    = 1'b1;
    smp_is_end = is_end;
    smp_i      = SMP_W'(i);
    smp_q      = SMP_W'(q);
    @(negedge clk);
    smp_vld    = 1'b0;
  endtask

  task automatic symbol(input int mi, input int mq, input int ei, input int eq);
    drive(1'b0, mi, mq);
    drive(1'b1, ei, eq);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 err in reset", int'(err), 0);
    chk("R1 vld in reset", int'(err_vld), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 err after release", int'(err), 0);
  endtask

  initial begin
    rst_n = 1'b0; smp_vld = 1'b0; smp_is_end = 1'b0;
    smp_i = '0; smp_q = '0; double_rail = 1'b1; freeze = 1'b0;
    @(negedge clk);
    do_reset();

    // priming symbol: both decisions become 1, no strobe
    symbol(0, 0, 5, 5);
    chk("R9 first end no strobe", int'(err_vld), 0);

    for (int k = 0; k < NV; k++) begin
      double_rail = DB[k][0];
      symbol(MI[k], MQ[k], EI[k], EQ[k]);
      chk({RQ[k], " err"}, int'(err), EX[k]);
      chk("R8 strobe", int'(err_vld), 1);
      @(negedge clk);
      chk("R8 strobe one cycle", int'(err_vld), 0);
    end

    // R10: frozen symbol with falling I and Q decisions
    double_rail = 1'b1;
    freeze = 1'b1;
    symbol(80, 0, -4, -3);
    chk("R10 no strobe when frozen", int'(err_vld), 0);
    chk("R10 err held", int'(err), 511);
    freeze = 1'b0;
    symbol(90, 0, 6, -3);
    chk("R10 decision tracked in freeze", int'(err), 90);
    chk("R10 strobe after freeze", int'(err_vld), 1);

    // R11: several mid samples, latest one counts
    drive(1'b0, 10, 0);
    chk("R11 mid no strobe", int'(err_vld), 0);
    drive(1'b0, 20, 0);
    chk("R11 mid no strobe", int'(err_vld), 0);
    drive(1'b0, 30, 0);
    drive(1'b1, -1, -1);
    chk("R11 latest mid used", int'(err), -30);

    // mid-run reset, then first symbol ignored (R9)
    @(negedge clk);
    do_reset();
    symbol(0, 0, -5, -5);
    chk("R9 first end after reset no strobe", int'(err_vld), 0);
    symbol(45, 0, 5, -5);
    chk("R3 rise after reset", int'(err), 45);
    chk("R9 strobe on second end", int'(err_vld), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule